// File: doc/BRIEF.md
# Shared-Line Interrupt Event Controller

This block gathers five interrupt sources and signals them on one shared, active-low interrupt wire. The five sources are:

- an end-of-conversion pulse from an A/D converter;
- a change on any bit of an 8-bit input port;
- a falling edge of a timer output;
- rising edges on two fixed port bits, bit 3 and bit 0.

Each source has its own enable, and a global enable gates the whole line. When an enabled event is pending and the line is armed, the block pulls the wire low for a configurable number of clocks. It then drives the wire high for two clocks and lets it float, so several boards can share one wire.

Software sees four views of the block:

- a change register that collects port bit toggles and clears when it is read;
- an event status register with its own read-clear strobe;
- a cause view that shows the pending flags and whether the line is raised;
- a clear strobe used to service the line.

A raised line is not re-armed until at least one of the sources pending at fire time has been serviced. Timer and port-edge sources need only the clear strobe. Converter and change sources also need their data to be read, in either order. A source left unserviced then raises the line again.

The line sequencer has four states:

| State | Line |
|-------|------|
| IDLE | released |
| PULL | driven low |
| PUSH | driven high |
| HOLD | released, waiting for service |

Its transitions are:

- IDLE to PULL when the global enable is set and a flag is pending.
- PULL to PUSH after LOW_CYC clocks.
- PUSH to HOLD after two clocks.
- HOLD to IDLE once a source claimed at fire time is serviced.

Top module: `irq_cos_ctrl`

## Requirements
- R1: Each bit of `chg_o` sets when the matching synchronized port bit toggles and stays set, so toggles on different bits accumulate. During a `rd_chg_i` strobe `chg_o` shows the collected value, and it reads 0x00 the cycle after unless a new toggle arrives.
- R2: `stat_o[7]` latches an end-of-conversion pulse and `stat_o[6]` latches any port change, whatever the enables are. Both clear after a `rd_stat_i` strobe.
- R3: `stat_o[2]` mirrors the global enable and a status read does not clear it. `stat_o` bits 5, 4, 3, 1 and 0 read zero.
- R4: The enable register is written with `en_wr_i` and `en_wdata_i[7:2]`, and it is zero after reset. Bit 2 is the global enable, and no pulse starts while it is 0.
- R5: `cause_o` bit 7 is the conversion flag, bit 6 the port change, bit 5 the timer fall, bit 4 the port bit 3 rise and bit 3 the port bit 0 rise. `cause_o[2]` is high from the first low clock of a pulse until the line is re-armed. Bits 1 and 0 read zero.
- R6: A pulse holds `irq_oe_o`=1 and `irq_n_o`=0 for exactly LOW_CYC clocks, then `irq_oe_o`=1 and `irq_n_o`=1 for two clocks, then `irq_oe_o`=0.
- R7: Timer-fall and port-bit-rise flags clear on a `wr_clr_i` strobe alone. A timer rising edge and port bit falling edges set no flag.
- R8: The conversion flag clears only after both `wr_clr_i` and `rd_adc_i`, and the change flag only after both `wr_clr_i` and `rd_chg_i`, in either order.
- R9: After a pulse no new pulse starts until a source that was pending when the pulse began is serviced. A flag still pending then starts another pulse.
- R10: A source whose enable bit is 0 sets no pending flag. Port inputs pass through a two-flop synchronizer before edge detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_i | input | 8 | Asynchronous input port watched for changes |
| tmr_out_i | input | 1 | Timer output level, synchronous to clk |
| adc_done_i | input | 1 | One-clock end-of-conversion pulse |
| en_wr_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 6 | Enable write data, bits 7 down to 2 |
| wr_clr_i | input | 1 | Interrupt clear strobe |
| rd_stat_i | input | 1 | Status read strobe (clears event latches) |
| rd_chg_i | input | 1 | Change register read strobe (clears it) |
| rd_adc_i | input | 1 | Converter data read strobe |
| stat_o | output | 8 | Event status view |
| cause_o | output | 8 | Pending flags and raised indicator |
| chg_o | output | 8 | Accumulated per-bit change register |
| irq_oe_o | output | 1 | Interrupt line drive enable |
| irq_n_o | output | 1 | Interrupt line level while driven |

## Verification
Some behaviours are checked on every cycle:

- the exact low width;
- the two-clock high tail followed by release;
- that no pulse starts without the global enable;
- that no pulse restarts while the raised indicator is still set;
- that change and status bits drop only after their read strobes.

Other behaviours can only be shown by the directed scenarios:

- the two-part servicing rule in both orders;
- that a remaining source fires again once its partner is serviced;
- that opposite edges and disabled sources leave the flags untouched.

// File: rtl/irq_cos_pkg.sv
package irq_cos_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PULL,
        ST_PUSH,
        ST_HOLD
    } line_state_t;

    localparam int unsigned NSRC      = 5;
    localparam int unsigned SRC_LSB   = 3;
    localparam int unsigned GEN_BIT   = 2;
    localparam int unsigned PORT_W    = 8;
    // sources 4 (conversion) and 3 (port change) also need a data read
    localparam logic [NSRC-1:0] NEED_DATA = 5'b11000;

endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2,
    parameter int unsigned NTAP   = 2,
    parameter logic [NTAP-1:0][7:0] TAP = {8'd3, 8'd0}
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    din,
    output logic [W-1:0]    toggle,
    output logic [NTAP-1:0] tap_rise
);

    logic [STAGES-1:0][W-1:0] stg;
    logic [W-1:0]             prev;
    logic [W-1:0]             lvl;

    assign lvl = stg[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg  <= '0;
            prev <= '0;
        end else begin
            stg[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
            prev <= lvl;
        end
    end

    assign toggle = lvl ^ prev;

    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        localparam int unsigned IB = int'(TAP[t]);
        assign tap_rise[t] = lvl[IB] & ~prev[IB];
    end

endmodule

// File: rtl/irq_event_latch.sv
module irq_event_latch #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adc_evt,
    input  logic [W-1:0] tog,
    input  logic         rd_stat,
    input  logic         rd_chg,
    input  logic         gen,
    output logic [7:0]   stat,
    output logic [W-1:0] chg
);

    logic         eoc_q;
    logic         cos_q;
    logic [W-1:0] chg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eoc_q <= 1'b0;
            cos_q <= 1'b0;
            chg_q <= '0;
        end else begin
            // a new event in the read cycle wins over the clear
            eoc_q <= adc_evt | (eoc_q & ~rd_stat);
            cos_q <= (|tog) | (cos_q & ~rd_stat);
            chg_q <= tog | (chg_q & ~{W{rd_chg}});
        end
    end

    assign stat = {eoc_q, cos_q, 3'b000, gen, 2'b00};
    assign chg  = chg_q;

endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
    parameter int unsigned      NSRC = 5,
    parameter logic [NSRC-1:0]  NEED = 5'b11000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic            wr_clr,
    input  logic [NSRC-1:0] rd_data,
    output logic [NSRC-1:0] pend,
    output logic [NSRC-1:0] done
);

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        logic pend_q;
        logic clr_seen_q;
        logic rd_seen_q;
        logic svc_clr;
        logic svc_rd;

        assign svc_clr = clr_seen_q | wr_clr;
        assign svc_rd  = ~NEED[k] | rd_seen_q | rd_data[k];
        assign done[k] = pend_q & svc_clr & svc_rd;
        assign pend[k] = pend_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q     <= 1'b0;
                clr_seen_q <= 1'b0;
                rd_seen_q  <= 1'b0;
            end else begin
                pend_q     <= evt[k] | (pend_q & ~done[k]);
                clr_seen_q <= pend_q & ~done[k] & svc_clr;
                rd_seen_q  <= pend_q & ~done[k] & (rd_seen_q | rd_data[k]);
            end
        end
    end

endmodule

// File: rtl/irq_line_seq.sv
module irq_line_seq
    import irq_cos_pkg::*;
#(
    parameter int unsigned LOW_CYC  = 25,
    parameter int unsigned HIGH_CYC = 2,
    parameter int unsigned NS       = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gen,
    input  logic [NS-1:0] pend,
    input  logic [NS-1:0] done,
    output logic          oe,
    output logic          lvl_n,
    output logic          raised
);

    localparam int unsigned CMAX = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int unsigned CW   = $clog2(CMAX + 1);

    line_state_t   st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic [NS-1:0] claim_q;
    logic          hit_q;
    logic          fire, low_end, high_end, svc_now;

    assign fire     = gen && (|pend);
    assign low_end  = (cnt_q == CW'(LOW_CYC - 1));
    assign high_end = (cnt_q == CW'(HIGH_CYC - 1));
    assign svc_now  = hit_q || (|(claim_q & done));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (fire)     st_d = ST_PULL;
            ST_PULL: if (low_end)  st_d = ST_PUSH;
            ST_PUSH: if (high_end) st_d = ST_HOLD;
            ST_HOLD: if (svc_now)  st_d = ST_IDLE;
            default:               st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            claim_q <= '0;
            hit_q   <= 1'b0;
        end else begin
            if (st_q != st_d)                          cnt_q <= '0;
            else if (st_q == ST_PULL || st_q == ST_PUSH) cnt_q <= cnt_q + 1'b1;

            if (st_q == ST_IDLE && fire) begin
                claim_q <= pend;
                hit_q   <= 1'b0;
            end else if (st_q != ST_IDLE) begin
                hit_q   <= hit_q | (|(claim_q & done));
            end
        end
    end

    always_comb begin
        oe     = 1'b0;
        lvl_n  = 1'b1;
        raised = 1'b1;
        unique case (st_q)
            ST_IDLE: raised = 1'b0;
            ST_PULL: begin oe = 1'b1; lvl_n = 1'b0; end
            ST_PUSH: oe = 1'b1;
            ST_HOLD: ;
            default: raised = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_cos_ctrl.sv
module irq_cos_ctrl
    import irq_cos_pkg::*;
#(
    parameter int unsigned LOW_CYC = 25,
    parameter int unsigned SYNC_N  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] port_i,
    input  logic       tmr_out_i,
    input  logic       adc_done_i,
    input  logic       en_wr_i,
    input  logic [7:2] en_wdata_i,
    input  logic       wr_clr_i,
    input  logic       rd_stat_i,
    input  logic       rd_chg_i,
    input  logic       rd_adc_i,
    output logic [7:0] stat_o,
    output logic [7:0] cause_o,
    output logic [7:0] chg_o,
    output logic       irq_oe_o,
    output logic       irq_n_o
);

    logic [PORT_W-1:0] prt_tog;
    logic [1:0]        prt_rise;
    logic              tmr_q, tmr_fall;
    logic [7:2]        en_q;
    logic [NSRC-1:0]   evt, rd_vec, pend, done;
    logic              raised;

    irq_sync_edge #(
        .W(PORT_W), .STAGES(SYNC_N), .NTAP(2), .TAP({8'd3, 8'd0})
    ) u_port (
        .clk(clk), .rst_n(rst_n), .din(port_i),
        .toggle(prt_tog), .tap_rise(prt_rise)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= 1'b0;
            en_q  <= '0;
        end else begin
            tmr_q <= tmr_out_i;
            if (en_wr_i) en_q <= en_wdata_i;
        end
    end

    assign tmr_fall = tmr_q & ~tmr_out_i;

    assign evt = {adc_done_i & en_q[7],
                  (|prt_tog) & en_q[6],
                  tmr_fall   & en_q[5],
                  prt_rise[1] & en_q[4],
                  prt_rise[0] & en_q[3]};

    assign rd_vec = {rd_adc_i, rd_chg_i, 3'b000};

    irq_event_latch #(.W(PORT_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .adc_evt(adc_done_i), .tog(prt_tog),
        .rd_stat(rd_stat_i), .rd_chg(rd_chg_i), .gen(en_q[GEN_BIT]),
        .stat(stat_o), .chg(chg_o)
    );

    irq_pend #(.NSRC(NSRC), .NEED(NEED_DATA)) u_pend (
        .clk(clk), .rst_n(rst_n), .evt(evt), .wr_clr(wr_clr_i),
        .rd_data(rd_vec), .pend(pend), .done(done)
    );

    irq_line_seq #(.LOW_CYC(LOW_CYC), .HIGH_CYC(2), .NS(NSRC)) u_seq (
        .clk(clk), .rst_n(rst_n), .gen(en_q[GEN_BIT]), .pend(pend),
        .done(done), .oe(irq_oe_o), .lvl_n(irq_n_o), .raised(raised)
    );

    assign cause_o = {pend, raised, 2'b00};

endmodule

// File: rtl/irq_cos_ctrl_chk.sv
module irq_cos_ctrl_chk #(
    parameter int unsigned LOW_CYC = 25
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_stat_i,
    input logic       rd_chg_i,
    input logic [7:0] stat_o,
    input logic [7:0] cause_o,
    input logic [7:0] chg_o,
    input logic       irq_oe_o,
    input logic       irq_n_o
);

    logic [15:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      low_run <= '0;
        else if (irq_oe_o && !irq_n_o)   low_run <= low_run + 16'd1;
        else                             low_run <= '0;
    end

    p_low_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_oe_o && irq_n_o && $past(irq_oe_o && !irq_n_o)) |-> (low_run == 16'(LOW_CYC)));

    p_low_then_driven_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_oe_o && !irq_n_o) |=> irq_oe_o);

    p_high_two_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_oe_o && irq_n_o) |=> (irq_oe_o && irq_n_o));

    p_high_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_oe_o && irq_n_o && $past(irq_oe_o && irq_n_o)) |=> !irq_oe_o);

    p_fire_needs_gen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_oe_o) |-> $past(stat_o[2]));

    p_raised_with_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cause_o[2]) |-> $rose(irq_oe_o));

    p_no_refire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_o[2] && $past(cause_o[2])) |-> !$rose(irq_oe_o));

    p_chg_clear_on_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(chg_o) & ~chg_o)) |-> $past(rd_chg_i));

    p_stat_clear_on_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(stat_o[7]) || $fell(stat_o[6])) |-> $past(rd_stat_i));

endmodule

bind irq_cos_ctrl irq_cos_ctrl_chk #(.LOW_CYC(LOW_CYC)) u_chk (.*);

// File: tb/irq_cos_ctrl_bench.sv
module irq_cos_ctrl_bench;

    localparam int LOW = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] port_i = 8'h00;
    logic       tmr_out_i = 1'b1;
    logic       adc_done_i = 1'b0;
    logic       en_wr_i = 1'b0;
    logic [7:2] en_wdata_i = '0;
    logic       wr_clr_i = 1'b0;
    logic       rd_stat_i = 1'b0;
    logic       rd_chg_i = 1'b0;
    logic       rd_adc_i = 1'b0;
    logic [7:0] stat_o, cause_o, chg_o;
    logic       irq_oe_o, irq_n_o;

    int checks = 0;
    int failures = 0;

    irq_cos_ctrl #(.LOW_CYC(LOW)) u_irq_cos_ctrl (.*);

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_en(input logic [7:0] v);
        en_wr_i = 1'b1; en_wdata_i = v[7:2];
        step(1);
        en_wr_i = 1'b0;
        step(1);
    endtask

    task automatic do_clr();
        wr_clr_i = 1'b1; step(1); wr_clr_i = 1'b0;
    endtask

    task automatic do_rd_adc();
        rd_adc_i = 1'b1; step(1); rd_adc_i = 1'b0;
    endtask

    task automatic do_rd_chg(output logic [7:0] v);
        rd_chg_i = 1'b1; v = chg_o; step(1); rd_chg_i = 1'b0;
    endtask

    task automatic do_rd_stat(output logic [7:0] v);
        rd_stat_i = 1'b1; v = stat_o; step(1); rd_stat_i = 1'b0;
    endtask

    task automatic pulse_adc();
        adc_done_i = 1'b1; step(1); adc_done_i = 1'b0;
    endtask

    task automatic catch_pulse(output bit seen, output int lo, output int hi);
        int i = 0;
        lo = 0; hi = 0;
        while (!irq_oe_o && i < 200) begin step(1); i++; end
        seen = irq_oe_o;
        if (seen) begin
            while (irq_oe_o && !irq_n_o) begin lo++; step(1); end
            while (irq_oe_o && irq_n_o)  begin hi++; step(1); end
        end
    endtask

    task automatic t_reset();
        chk("R4 stat after reset", stat_o, 8'h00);
        chk("R5 cause after reset", cause_o, 8'h00);
        chk("R1 chg after reset", chg_o, 8'h00);
        chk("R6 line released after reset", irq_oe_o, 0);
    endtask

    task automatic t_cos_accum();
        logic [7:0] v;
        port_i = 8'h10; step(5);
        chk("R1 first toggle", chg_o, 8'h10);
        port_i = 8'h30; step(5);
        chk("R1 accumulate", chg_o, 8'h30);
        do_rd_chg(v);
        chk("R1 read value", v, 8'h30);
        chk("R1 cleared after read", chg_o, 8'h00);
        chk("R2 change latched while disabled", stat_o, 8'h40);
        chk("R10 disabled source not pending", cause_o, 8'h00);
        chk("R10 no line drive", irq_oe_o, 0);
        do_rd_stat(v);
        chk("R2 status read value", v, 8'h40);
        chk("R2 status cleared", stat_o, 8'h00);
    endtask

    task automatic t_gen_flag();
        logic [7:0] v;
        wr_en(8'h04);
        chk("R3 global enable shown", stat_o, 8'h04);
        do_rd_stat(v);
        chk("R3 read value", v, 8'h04);
        chk("R3 not cleared by read", stat_o, 8'h04);
        chk("R4 no pulse with nothing pending", irq_oe_o, 0);
    endtask

    task automatic t_no_gen();
        bit s; int lo, hi; logic [7:0] v;
        wr_en(8'h80);
        pulse_adc(); step(3);
        chk("R4 pending without global enable", cause_o, 8'h80);
        chk("R4 no drive without global enable", irq_oe_o, 0);
        wr_en(8'h84);
        catch_pulse(s, lo, hi);
        chk("R4 pulse once global enabled", s, 1);
        do_clr(); do_rd_adc(); step(1);
        chk("R8 serviced after enable", cause_o, 8'h00);
        do_rd_stat(v);
    endtask

    task automatic t_adc();
        bit s; int lo, hi; logic [7:0] v;
        wr_en(8'h84);
        pulse_adc();
        catch_pulse(s, lo, hi);
        chk("R6 pulse seen", s, 1);
        chk("R6 low width", lo, LOW);
        chk("R6 high width", hi, 2);
        step(2);
        chk("R6 released", irq_oe_o, 0);
        chk("R5 cause conversion", cause_o, 8'h84);
        chk("R2 conversion latched", stat_o, 8'h84);
        do_clr(); step(2);
        chk("R8 clear alone keeps flag", cause_o, 8'h84);
        do_rd_adc(); step(1);
        chk("R8 clear then read services", cause_o, 8'h00);
        do_rd_stat(v);
        chk("R2 conversion cleared", stat_o, 8'h04);
        pulse_adc();
        catch_pulse(s, lo, hi);
        chk("R6 second pulse", s, 1);
        step(1);
        do_rd_adc(); step(1);
        chk("R8 read alone keeps flag", cause_o, 8'h84);
        do_clr(); step(1);
        chk("R8 read then clear services", cause_o, 8'h00);
        do_rd_stat(v);
    endtask

    task automatic t_timer();
        bit s; int lo, hi;
        wr_en(8'h24);
        tmr_out_i = 1'b0;
        catch_pulse(s, lo, hi);
        chk("R7 timer fall pulse", s, 1);
        step(1);
        chk("R7 timer flag", cause_o, 8'h24);
        do_clr(); step(1);
        chk("R7 clear alone services timer", cause_o, 8'h00);
        tmr_out_i = 1'b1; step(5);
        chk("R7 timer rise no flag", cause_o, 8'h00);
        chk("R7 timer rise no drive", irq_oe_o, 0);
    endtask

    task automatic t_port_edges();
        bit s; int lo, hi; logic [7:0] v;
        wr_en(8'h1C);
        port_i = 8'h38;
        catch_pulse(s, lo, hi);
        chk("R7 bit3 rise pulse", s, 1);
        chk("R5 bit3 rise flag", cause_o, 8'h14);
        do_clr(); step(1);
        chk("R7 bit3 serviced", cause_o, 8'h00);
        port_i = 8'h39;
        catch_pulse(s, lo, hi);
        chk("R7 bit0 rise pulse", s, 1);
        chk("R5 bit0 rise flag", cause_o, 8'h0C);
        do_clr(); step(1);
        chk("R7 bit0 serviced", cause_o, 8'h00);
        port_i = 8'h30; step(6);
        chk("R7 falling bits no flag", cause_o, 8'h00);
        chk("R7 falling bits no drive", irq_oe_o, 0);
        do_rd_chg(v);
        do_rd_stat(v);
    endtask

    task automatic t_two();
        bit s; int lo, hi; int drove = 0; logic [7:0] v;
        wr_en(8'hC4);
        port_i = 8'h32; adc_done_i = 1'b1; step(1); adc_done_i = 1'b0;
        catch_pulse(s, lo, hi);
        chk("R9 first pulse", s, 1);
        step(2);
        chk("R9 both pending", cause_o, 8'hC4);
        for (int i = 0; i < 30; i++) begin
            if (irq_oe_o) drove++;
            step(1);
        end
        chk("R9 no refire before service", drove, 0);
        do_clr(); step(2);
        chk("R9 still raised after clear only", cause_o, 8'hC4);
        do_rd_adc();
        catch_pulse(s, lo, hi);
        chk("R9 remaining source refires", s, 1);
        chk("R9 refire low width", lo, LOW);
        chk("R9 remaining flag", cause_o, 8'h44);
        do_clr(); do_rd_chg(v); step(1);
        chk("R8 change serviced", cause_o, 8'h00);
        do_rd_stat(v);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_cos_accum();
        t_gen_flag();
        t_no_gen();
        t_adc();
        t_timer();
        t_port_edges();
        t_two();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule